// File: doc/BRIEF.md
# PWM Trip Protection Unit

This block sits between a PWM generator and the output pins. It forces the two PWM outputs, A and B, to configured safe states when selected trip inputs fire. Two trip mechanisms run side by side. A cycle-based trip releases by itself at a chosen point of the PWM period, but only once its cause has gone away. A latched trip holds the override until software clears it. When both are active, the latched trip wins. Trip sources can include digital-compare events. Such events raise the shared interrupt through whichever mechanism selects them.

Each mechanism has its own source mask, applied as a live input. Software reaches the block through a small write-only port. It uses this port to set the override actions, the release point and the two interrupt enables, and to clear flags and the latched trip. The override may differ for trips that start while the counter counts up and for trips that start while it counts down. The outputs are the overridden pins, each as a data bit plus an output enable, together with sticky summary and per-source flags and one interrupt line.

Top module: `trip_guard`

## Requirements
- R1: An override starts in the same cycle that a selected trip input rises. While no trip is active or latched, each output passes its PWM input with the enable high.
- R2: Override codes work as follows. 00 releases the pin (enable low, data 0). 01 drives it high. 10 drives it low. 11 passes the PWM input through.
- R3: Config register, address 0: A basic [1:0], B basic [3:2], A up [5:4], A down [7:6], B up [9:8], B down [11:10], direction enable [12], release select [14:13]. With [12] set, each mechanism uses the up or down action, picked by `cnt_down` in the cycle its trip began. With [12] clear, the basic actions apply.
- R4: The cycle-based trip releases on a clock edge with an active release pulse, but only if no source it selects is high in that cycle. Release select 00 means `at_zero`, 01 means `at_period`, 10 means either, and 11 behaves as 00.
- R5: A cycle-based trip sets `cbc_flag` and the bit for each causing source in `cbc_src_flags` on the next edge. Both stay set until cleared. Address 2 bit 0 clears the summary flag. A write to address 3 clears the per-source bits whose data bits are 1.
- R6: If a source is still high in the cycle its flag is cleared, that flag remains set.
- R7: A latched trip sets `ost_flag` and holds the override until a write to address 2 with bit 1 set. Period boundaries do not release it. Address 4 clears `ost_src_flags` by mask.
- R8: While the latched trip is active, its action overrides the cycle-based action. When the cycle-based trip releases, an active latched override stays in place.
- R9: Address 1 holds the interrupt enables: bit 0 for the cycle-based flag, bit 1 for the latched flag. `irq` is high whenever an enabled flag is set.
- R10: Reset clears all latches, flags, enables and configuration.
- R11: Sources outside a mechanism's mask affect neither its override nor its flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_a_in | input | 1 | PWM value for output A |
| pwm_b_in | input | 1 | PWM value for output B |
| trip_in | input | N_SRC | Synchronous active-high trip sources |
| cbc_sel | input | N_SRC | Sources feeding the cycle-based trip |
| ost_sel | input | N_SRC | Sources feeding the latched trip |
| cnt_down | input | 1 | 1 while the PWM counter counts down |
| at_zero | input | 1 | Pulse when the counter equals zero |
| at_period | input | 1 | Pulse when the counter equals period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_a_out | output | 1 | Output A data |
| pwm_a_oe | output | 1 | Output A enable |
| pwm_b_out | output | 1 | Output B data |
| pwm_b_oe | output | 1 | Output B enable |
| cbc_flag | output | 1 | Sticky cycle-based trip flag |
| ost_flag | output | 1 | Latched trip state and flag |
| cbc_src_flags | output | N_SRC | Sticky causing-source flags, cycle-based |
| ost_src_flags | output | N_SRC | Sticky causing-source flags, latched |
| irq | output | 1 | Shared trip interrupt |

## Verification
The assertions check several properties on every cycle. The outputs pass through while no trip exists. A flag whose source is present gets set, even when a clear arrives in the same cycle. The latched trip never drops without its clear write. The cycle-based latch never drops outside a release pulse. `irq` stays low while both flags are clear. Other behaviours can only be shown by the bench's scenarios, which compare against a reference model: which action code reaches each pin, the direction captured at trip onset, the decoding of each release select, priority under overlapping trips, and the per-mask clear effects.

// File: rtl/trip_guard.sv
module trip_guard #(
  parameter int N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_a_in,
  input  logic             pwm_b_in,
  input  logic [N_SRC-1:0] trip_in,
  input  logic [N_SRC-1:0] cbc_sel,
  input  logic [N_SRC-1:0] ost_sel,
  input  logic             cnt_down,
  input  logic             at_zero,
  input  logic             at_period,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [15:0]      wr_data,
  output logic             pwm_a_out,
  output logic             pwm_a_oe,
  output logic             pwm_b_out,
  output logic             pwm_b_oe,
  output logic             cbc_flag,
  output logic             ost_flag,
  output logic [N_SRC-1:0] cbc_src_flags,
  output logic [N_SRC-1:0] ost_src_flags,
  output logic             irq
);
  localparam logic [2:0] A_CFG = 3'd0, A_IE = 3'd1, A_CLR = 3'd2, A_CSRC = 3'd3, A_OSRC = 3'd4;
  localparam logic [1:0] PASS = 2'b11;

  logic [14:0] cfg;
  logic [1:0]  ie;
  logic        cbc_lat, cbc_dir, ost_lat, ost_dir, cbc_flag_q;
  logic [N_SRC-1:0] cbc_src_q, ost_src_q;

  wire [N_SRC-1:0] cbc_hits = trip_in & cbc_sel;
  wire [N_SRC-1:0] ost_hits = trip_in & ost_sel;
  wire cbc_hit = |cbc_hits;
  wire ost_hit = |ost_hits;

  wire wr_cfg  = wr_en && wr_addr == A_CFG;
  wire wr_ie   = wr_en && wr_addr == A_IE;
  wire wr_clr  = wr_en && wr_addr == A_CLR;
  wire wr_csrc = wr_en && wr_addr == A_CSRC;
  wire wr_osrc = wr_en && wr_addr == A_OSRC;

  logic rel_pulse;
  always_comb begin
    case (cfg[14:13])
      2'b01:   rel_pulse = at_period;
      2'b10:   rel_pulse = at_zero | at_period;
      default: rel_pulse = at_zero;
    endcase
  end

  wire cbc_on  = cbc_lat | cbc_hit;
  wire ost_on  = ost_lat | ost_hit;
  wire cbc_dnow = cbc_lat ? cbc_dir : cnt_down;
  wire ost_dnow = ost_lat ? ost_dir : cnt_down;

  function automatic logic [1:0] pick(input logic [1:0] basic, input logic [1:0] up,
                                      input logic [1:0] dn, input logic en, input logic dir);
    if (!en) return basic;
    return dir ? dn : up;
  endfunction

  function automatic logic [1:0] pin(input logic [1:0] code, input logic pwm);
    case (code)
      2'b00:   return 2'b00;
      2'b01:   return 2'b11;
      2'b10:   return 2'b10;
      default: return {1'b1, pwm};
    endcase
  endfunction

  wire [1:0] a_cbc = pick(cfg[1:0], cfg[5:4], cfg[7:6], cfg[12], cbc_dnow);
  wire [1:0] a_ost = pick(cfg[1:0], cfg[5:4], cfg[7:6], cfg[12], ost_dnow);
  wire [1:0] b_cbc = pick(cfg[3:2], cfg[9:8], cfg[11:10], cfg[12], cbc_dnow);
  wire [1:0] b_ost = pick(cfg[3:2], cfg[9:8], cfg[11:10], cfg[12], ost_dnow);

  wire [1:0] a_code = ost_on ? a_ost : cbc_on ? a_cbc : PASS;
  wire [1:0] b_code = ost_on ? b_ost : cbc_on ? b_cbc : PASS;

  assign {pwm_a_oe, pwm_a_out} = pin(a_code, pwm_a_in);
  assign {pwm_b_oe, pwm_b_out} = pin(b_code, pwm_b_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg        <= '0;
      ie         <= '0;
      cbc_lat    <= 1'b0;
      cbc_dir    <= 1'b0;
      ost_lat    <= 1'b0;
      ost_dir    <= 1'b0;
      cbc_flag_q <= 1'b0;
      cbc_src_q  <= '0;
      ost_src_q  <= '0;
    end else begin
      if (wr_cfg) cfg <= wr_data[14:0];
      if (wr_ie)  ie  <= wr_data[1:0];

      if (cbc_hit)        cbc_lat <= 1'b1;
      else if (rel_pulse) cbc_lat <= 1'b0;
      if (cbc_hit && !cbc_lat) cbc_dir <= cnt_down;

      if (ost_hit)                  ost_lat <= 1'b1;
      else if (wr_clr && wr_data[1]) ost_lat <= 1'b0;
      if (ost_hit && !ost_lat) ost_dir <= cnt_down;

      cbc_flag_q <= cbc_hit | (cbc_flag_q & ~(wr_clr & wr_data[0]));
      cbc_src_q  <= cbc_hits | (cbc_src_q & ~(wr_csrc ? wr_data[N_SRC-1:0] : '0));
      ost_src_q  <= ost_hits | (ost_src_q & ~(wr_osrc ? wr_data[N_SRC-1:0] : '0));
    end
  end

  assign cbc_flag      = cbc_flag_q;
  assign ost_flag      = ost_lat;
  assign cbc_src_flags = cbc_src_q;
  assign ost_src_flags = ost_src_q;
  assign irq           = (cbc_flag_q & ie[0]) | (ost_lat & ie[1]);
endmodule

// File: rtl/trip_guard_chk.sv
module trip_guard_chk #(
  parameter int N_SRC = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_a_in,
  input logic             pwm_b_in,
  input logic [N_SRC-1:0] trip_in,
  input logic [N_SRC-1:0] cbc_sel,
  input logic [N_SRC-1:0] ost_sel,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [15:0]      wr_data,
  input logic             pwm_a_out,
  input logic             pwm_a_oe,
  input logic             pwm_b_out,
  input logic             pwm_b_oe,
  input logic             cbc_flag,
  input logic             ost_flag,
  input logic [N_SRC-1:0] cbc_src_flags,
  input logic             irq,
  input logic             cbc_lat,
  input logic             ost_lat,
  input logic             rel_pulse
);
  wire any_c = |(trip_in & cbc_sel);
  wire any_o = |(trip_in & ost_sel);
  wire ost_clr = wr_en && wr_addr == 3'd2 && wr_data[1];

  AST_PASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cbc_lat && !ost_lat && !any_c && !any_o) |->
      (pwm_a_oe && pwm_a_out == pwm_a_in && pwm_b_oe && pwm_b_out == pwm_b_in)); // R1
  AST_CBC_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    any_c |=> cbc_flag); // R5
  AST_SRC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    any_c |=> ((cbc_src_flags & $past(trip_in & cbc_sel)) == $past(trip_in & cbc_sel))); // R6
  AST_OST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ost_flag && !ost_clr) |=> ost_flag); // R7
  AST_CBC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cbc_lat && !rel_pulse) |=> cbc_lat); // R4
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cbc_flag && !ost_flag) |-> !irq); // R9
endmodule

bind trip_guard trip_guard_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in),
  .trip_in(trip_in), .cbc_sel(cbc_sel), .ost_sel(ost_sel),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pwm_a_out(pwm_a_out), .pwm_a_oe(pwm_a_oe), .pwm_b_out(pwm_b_out), .pwm_b_oe(pwm_b_oe),
  .cbc_flag(cbc_flag), .ost_flag(ost_flag), .cbc_src_flags(cbc_src_flags), .irq(irq),
  .cbc_lat(cbc_lat), .ost_lat(ost_lat), .rel_pulse(rel_pulse)
);

// File: tb/sim_trip_guard.sv
`timescale 1ns/1ps
module sim_trip_guard;
  localparam int N = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pa = 1'b0, pb = 1'b0, down = 1'b0, az = 1'b0, ap = 1'b0, we = 1'b0;
  logic [N-1:0] trip = '0, csel = '0, osel = '0;
  logic [2:0] wa = '0;
  logic [15:0] wd = '0;
  logic a_out, a_oe, b_out, b_oe, cf, of, irq;
  logic [N-1:0] cs, os;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trip_guard #(.N_SRC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_a_in(pa), .pwm_b_in(pb), .trip_in(trip),
    .cbc_sel(csel), .ost_sel(osel), .cnt_down(down), .at_zero(az), .at_period(ap),
    .wr_en(we), .wr_addr(wa), .wr_data(wd),
    .pwm_a_out(a_out), .pwm_a_oe(a_oe), .pwm_b_out(b_out), .pwm_b_oe(b_oe),
    .cbc_flag(cf), .ost_flag(of), .cbc_src_flags(cs), .ost_src_flags(os), .irq(irq));

  // reference model state
  logic [15:0] m_cfg = '0;
  logic [1:0]  m_ie = '0;
  bit m_cl = 0, m_cd = 0, m_ol = 0, m_od = 0, m_cf = 0;
  logic [N-1:0] m_cs = '0, m_os = '0;
  int cyc = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int act_code(input bit is_b, input bit dir);
    int basic, up, dn;
    basic = is_b ? int'(m_cfg[3:2]) : int'(m_cfg[1:0]);
    up    = is_b ? int'(m_cfg[9:8]) : int'(m_cfg[5:4]);
    dn    = is_b ? int'(m_cfg[11:10]) : int'(m_cfg[7:6]);
    if (!m_cfg[12]) return basic;
    return dir ? dn : up;
  endfunction

  function automatic int pin_val(input int code, input bit pwm);
    if (code == 0) return 0;
    if (code == 1) return 3;
    if (code == 2) return 2;
    return 2 + int'(pwm);
  endfunction

  task automatic step(input string tag, input logic [N-1:0] t, input bit d, input bit z, input bit p,
                      input bit w = 0, input logic [2:0] a = 0, input logic [15:0] dat = 0);
    bit ch, oh, rel, ca, oa, cdir, odir;
    int ca_code, cb_code, sel;
    @(negedge clk);
    cyc++;
    pa = cyc[0]; pb = cyc[1];
    trip = t; down = d; az = z; ap = p; we = w; wa = a; wd = dat;
    #2;
    ch = |(t & csel); oh = |(t & osel);
    ca = m_cl || ch; oa = m_ol || oh;
    cdir = m_cl ? m_cd : d; odir = m_ol ? m_od : d;
    ca_code = oa ? act_code(0, odir) : ca ? act_code(0, cdir) : 3;
    cb_code = oa ? act_code(1, odir) : ca ? act_code(1, cdir) : 3;
    chk(tag, "pin A {oe,out}", int'({a_oe, a_out}), pin_val(ca_code, pa));
    chk(tag, "pin B {oe,out}", int'({b_oe, b_out}), pin_val(cb_code, pb));
    chk(tag, "cbc_flag", int'(cf), int'(m_cf));
    chk(tag, "ost_flag", int'(of), int'(m_ol));
    chk(tag, "cbc_src_flags", int'(cs), int'(m_cs));
    chk(tag, "ost_src_flags", int'(os), int'(m_os));
    chk(tag, "irq", int'(irq), int'((m_cf && m_ie[0]) || (m_ol && m_ie[1])));
    sel = int'(m_cfg[14:13]);
    rel = (sel == 1) ? p : (sel == 2) ? (z || p) : z;
    if (ch && !m_cl) m_cd = d;
    m_cl = ch ? 1 : (rel ? 0 : m_cl);
    if (oh && !m_ol) m_od = d;
    m_ol = oh ? 1 : ((w && a == 2 && dat[1]) ? 0 : m_ol);
    m_cf = ch || (m_cf && !(w && a == 2 && dat[0]));
    m_cs = (t & csel) | (m_cs & ~((w && a == 3) ? dat[N-1:0] : '0));
    m_os = (t & osel) | (m_os & ~((w && a == 4) ? dat[N-1:0] : '0));
    if (w && a == 0) m_cfg = {1'b0, dat[14:0]};
    if (w && a == 1) m_ie = dat[1:0];
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, '0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #45 rst_n = 1'b1;
    // R10: reset state, pass-through, no flags
    idle("R10", 3);
    csel = 6'b000011; osel = 6'b001100;
    // R2 codes: A hi-z, B high
    step("R2", '0, 0, 0, 0, 1, 0, 16'b0_00_0_00_00_00_00_01_00);
    step("R1", 6'b000001, 0, 0, 0);          // R1 immediate override
    step("R4", 6'b000001, 0, 1, 0);          // R4 held while source present at zero
    step("R4", 6'b000000, 0, 0, 1);          // period does not release with select 00
    step("R4", 6'b000000, 0, 1, 0);          // released at zero
    idle("R1", 2);
    // R2: A low, B pass; R4 select 01 period
    step("R2", '0, 0, 0, 0, 1, 0, 16'b0_01_0_00_00_00_00_11_10);
    step("R2", 6'b000010, 1, 0, 0);
    step("R4", 6'b000000, 0, 1, 0);
    step("R4", 6'b000000, 0, 0, 1);
    // R4 select 10 either, then 11 behaves as zero
    step("R4", '0, 0, 0, 0, 1, 0, 16'b0_10_0_00_00_00_00_01_10);
    step("R4", 6'b000001, 0, 0, 0);
    step("R4", 6'b000000, 0, 0, 1);
    step("R4", 6'b000001, 0, 0, 0);
    step("R4", 6'b000000, 0, 1, 0);
    step("R4", '0, 0, 0, 0, 1, 0, 16'b0_11_0_00_00_00_00_01_10);
    step("R4", 6'b000001, 0, 0, 0);
    step("R4", 6'b000000, 0, 0, 1);
    step("R4", 6'b000000, 0, 1, 0);
    // R5/R6 flag clears: clear while source held, then after
    step("R6", 6'b000010, 0, 0, 0, 1, 2, 16'h0001);
    step("R6", 6'b000010, 0, 0, 0, 1, 3, 16'h0003);
    step("R5", 6'b000000, 0, 0, 0, 1, 3, 16'h0002);
    step("R5", 6'b000000, 0, 0, 0, 1, 2, 16'h0001);
    step("R5", 6'b000000, 0, 0, 0, 1, 3, 16'h0001);
    step("R4", 6'b000000, 0, 1, 0);
    // R9 interrupts
    step("R9", '0, 0, 0, 0, 1, 1, 16'h0001);
    step("R9", 6'b000001, 0, 0, 0);
    step("R9", '0, 0, 1, 0);
    step("R9", '0, 0, 0, 0, 1, 2, 16'h0001);
    step("R9", '0, 0, 0, 0, 1, 1, 16'h0002);
    // R7 latched trip, R8 priority (A: cbc low vs ost high via direction)
    step("R3", '0, 0, 0, 0, 1, 0, 16'b0_00_1_01_10_01_10_01_10);
    step("R8", 6'b000001, 0, 0, 0);          // cbc up -> A low, B low (up codes 10)
    step("R8", 6'b000101, 1, 0, 0);          // ost down -> A high, B high
    step("R7", 6'b000000, 0, 1, 1);          // cbc releases, ost stays
    step("R7", 6'b000000, 1, 1, 0);
    step("R7", 6'b000100, 0, 0, 0, 1, 2, 16'h0002);  // clear while held
    step("R7", 6'b000000, 0, 0, 0, 1, 4, 16'h0004);
    step("R7", 6'b000000, 0, 0, 0, 1, 2, 16'h0002);
    step("R9", '0, 0, 0, 0, 1, 2, 16'h0001);
    // R3 direction captured at onset, later cnt_down changes ignored
    step("R3", 6'b001000, 0, 0, 0);
    step("R3", 6'b000000, 1, 0, 0);
    step("R3", 6'b000010, 1, 1, 0, 1, 2, 16'h0002);
    step("R3", 6'b000010, 0, 0, 0);
    step("R3", 6'b000000, 0, 1, 0);
    // R3 with direction enable clear: basic actions
    step("R3", '0, 0, 0, 0, 1, 0, 16'b0_00_0_01_10_01_10_00_01);
    step("R3", 6'b000001, 1, 0, 0);
    step("R3", 6'b000000, 1, 1, 0);
    // R11 unselected sources
    step("R11", 6'b110000, 0, 0, 0);
    step("R11", 6'b110000, 1, 1, 1);
    idle("R11", 2);
    // R10 reset mid-operation
    step("R10", 6'b000100, 0, 0, 0);
    @(negedge clk); rst_n = 1'b0;
    m_cfg = '0; m_ie = '0; m_cl = 0; m_cd = 0; m_ol = 0; m_od = 0; m_cf = 0; m_cs = '0; m_os = '0;
    trip = '0;
    @(negedge clk); rst_n = 1'b1;
    idle("R10", 3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule